// File: doc/BRIEF.md
# Floating-Point Adder with Exception Control

This block adds two IEEE-754 operands in single or double format and produces the sum together with per-operation exception causes, sticky flags and a trap request. The precision mode picks the format. Single operands sit in the low 32 bits of each 64-bit operand bus, and double operands use the whole bus. A one-cycle start strobe launches an operation. On the next cycle the block presents the result, a destination write-enable and all status outputs, and pulses done.

Each operand is first sorted into a class: signalling NaN, quiet NaN, denormal, positive zero, negative zero, normal or infinity. The special cases are then resolved in a fixed priority. Arithmetic runs only when both operands are normal. It aligns the exponents, adds or subtracts the significands, normalises and rounds to nearest-even. Denormal operands are not computed: they raise an unimplemented-operation cause and force a trap. Any enabled overflow, underflow or inexact trap forces a trap on every operation. A trap blocks the destination write.

Top module: `fpadd_unit`

## Requirements
- R1: Mode 0 adds the single operands held in bits [31:0] and returns the result in bits [31:0] with bits [63:32] zero. The upper operand bits are ignored. Mode 1 adds 64-bit double operands.
- R2: The cause output is rebuilt for every operation. It reflects only the operation just finished, never an earlier one.
- R3: If either operand is a signalling NaN, cause bit 3 (invalid) is set and the result is the canonical quiet NaN. This check outranks every other special case.
- R4: If neither operand is a signalling NaN but one is a quiet NaN, the result is the canonical quiet NaN with no cause set. This case outranks a denormal partner. The canonical quiet NaN is 0x7FFFFFFF for single and 0x7FFFFFFFFFFFFFFF for double.
- R5: If neither operand is a NaN but one is denormal, cause bit 4 (unimplemented) is set, the result bus is zero, trap_req is 1 and dest_we is 0.
- R6: A normal operand added to a zero of either sign gives the normal operand unchanged. Zero plus zero gives +0, except that -0 plus -0 gives -0.
- R7: Two normal operands are added with round-to-nearest-even. cause bit 0 (inexact) is set when rounding discards nonzero bits. An exact zero sum is +0.
- R8: A rounded exponent reaching the all-ones value gives a signed infinity with cause bits 2 (overflow) and 0 set. A normalised exponent of zero or below gives a signed zero with cause bits 1 (underflow) and 0 set.
- R9: Infinity plus a finite value or a same-signed infinity gives that infinity. Infinities of opposite sign raise invalid and give the canonical quiet NaN.
- R10: trap_req is 1 whenever any of trap_en bits 2, 1 or 0 (overflow, underflow, inexact) is set, even when no exception occurs. It is also 1 for invalid with trap_en bit 3 set, and for unimplemented. It is 0 otherwise.
- R11: dest_we is the inverse of trap_req, so a trapped operation leaves the destination untouched.
- R12: flags_out is flags_in ORed bitwise with cause bits [3:0]. Flag bits are never cleared by the block.
- R13: done is 1 for exactly one cycle, the cycle after start. Result and status outputs hold until the next start. After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launches one operation |
| dbl_mode | input | 1 | 0 selects single, 1 selects double |
| opnd_a | input | 64 | First operand |
| opnd_b | input | 64 | Second operand |
| trap_en | input | 4 | Trap enables {invalid, overflow, underflow, inexact} |
| flags_in | input | 4 | Current sticky flags, same bit order |
| result | output | 64 | Sum or special-case value |
| dest_we | output | 1 | Destination write-enable |
| cause | output | 5 | {unimplemented, invalid, overflow, underflow, inexact} |
| flags_out | output | 4 | Updated sticky flags |
| trap_req | output | 1 | Trap request |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions treat trap_en and flags_in as the values present in the start cycle. The trap checks therefore compare the done cycle against the trap enables seen one clock earlier. They also assume start stays low during reset, so that done can always be traced to a start. The bench satisfies both conditions: it changes every input only on the falling clock edge, holds start high for a single cycle, and releases reset before the first operation.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;

    typedef enum logic [2:0] {
        CL_SNAN,
        CL_QNAN,
        CL_DENORM,
        CL_PZERO,
        CL_NZERO,
        CL_NORM,
        CL_INF
    } fp_class_e;

    localparam int NCAUSE = 5;
    localparam int NFLAG  = 4;

    // cause / flag bit positions
    localparam int CB_INX = 0;
    localparam int CB_UNF = 1;
    localparam int CB_OVF = 2;
    localparam int CB_INV = 3;
    localparam int CB_UNI = 4;

endpackage

// File: rtl/fpadd_classify.sv
module fpadd_classify
    import fpadd_pkg::*;
#(
    parameter int EW = 8,
    parameter int MW = 23
) (
    input  logic [EW+MW:0] op,
    output fp_class_e      cls
);
    logic [EW-1:0] expo;
    logic [MW-1:0] frac;

    always_comb begin
        expo = op[EW+MW-1:MW];
        frac = op[MW-1:0];
        if (&expo) begin
            if (frac == '0)      cls = CL_INF;
            else if (frac[MW-1]) cls = CL_QNAN;
            else                 cls = CL_SNAN;
        end else if (expo == '0) begin
            if (frac != '0)      cls = CL_DENORM;
            else if (op[EW+MW])  cls = CL_NZERO;
            else                 cls = CL_PZERO;
        end else begin
            cls = CL_NORM;
        end
    end
endmodule

// File: rtl/fpadd_core.sv
module fpadd_core #(
    parameter int EW = 8,
    parameter int MW = 23
) (
    input  logic [EW+MW:0] op_a,
    input  logic [EW+MW:0] op_b,
    output logic [EW+MW:0] sum,
    output logic           ovf,
    output logic           unf,
    output logic           inx
);
    localparam int SW  = MW + 1;          // significand with hidden bit
    localparam int XW  = SW + 3;          // plus guard, round, sticky
    localparam int LZW = $clog2(XW + 1);
    localparam int XEW = EW + 2;          // signed working exponent
    localparam logic signed [XEW-1:0] EMAX = {2'b00, {EW{1'b1}}};

    function automatic logic [LZW-1:0] lead_zeros(input logic [XW-1:0] v);
        logic [LZW-1:0] n;
        logic           hit;
        n   = LZW'(XW);
        hit = 1'b0;
        for (int i = XW - 1; i >= 0; i--) begin
            if (!hit && v[i]) begin
                n   = LZW'(XW - 1 - i);
                hit = 1'b1;
            end
        end
        return n;
    endfunction

    logic                  a_big, s_big, s_sm;
    logic [EW-1:0]         e_big, e_sm, dexp;
    logic [MW-1:0]         f_big, f_sm, frac_o;
    logic [XW-1:0]         m_big, m_sm0, m_al, mask, norm;
    logic                  lost, g_bit, r_bit, s_bit, up;
    logic [XW:0]           raw;
    logic [LZW-1:0]        lz;
    logic signed [XEW-1:0] exp_n, exp_f;
    logic [SW:0]           rnd;

    always_comb begin
        a_big = (op_a[EW+MW-1:0] >= op_b[EW+MW-1:0]);
        {s_big, e_big, f_big} = a_big ? op_a : op_b;
        {s_sm,  e_sm,  f_sm}  = a_big ? op_b : op_a;
        dexp  = e_big - e_sm;
        m_big = {1'b1, f_big, 3'b000};
        m_sm0 = {1'b1, f_sm,  3'b000};
        mask  = '0;

        // alignment with sticky collection
        if (dexp >= EW'(XW)) begin
            m_al = '0;
            lost = 1'b1;
        end else begin
            mask = ~({XW{1'b1}} << dexp);
            lost = |(m_sm0 & mask);
            m_al = m_sm0 >> dexp;
        end
        m_al[0] = m_al[0] | lost;

        if (s_big == s_sm) raw = {1'b0, m_big} + {1'b0, m_al};
        else               raw = {1'b0, m_big} - {1'b0, m_al};

        // normalisation
        if (raw[XW]) begin
            lz    = '0;
            norm  = {raw[XW:2], raw[1] | raw[0]};
            exp_n = $signed({2'b00, e_big}) + $signed(XEW'(1));
        end else begin
            lz    = lead_zeros(raw[XW-1:0]);
            norm  = raw[XW-1:0] << lz;
            exp_n = $signed({2'b00, e_big}) - $signed({{(XEW-LZW){1'b0}}, lz});
        end

        // round to nearest, ties to even
        g_bit  = norm[2];
        r_bit  = norm[1];
        s_bit  = norm[0];
        up     = g_bit & (r_bit | s_bit | norm[3]);
        rnd    = {1'b0, norm[XW-1:3]} + {{SW{1'b0}}, up};
        exp_f  = exp_n + $signed({{(XEW-1){1'b0}}, rnd[SW]});
        frac_o = rnd[SW] ? rnd[MW:1] : rnd[MW-1:0];

        sum = '0;
        ovf = 1'b0;
        unf = 1'b0;
        inx = 1'b0;
        if (raw == '0) begin
            sum = '0;
        end else if (exp_n[XEW-1] || exp_n == '0) begin
            sum = {s_big, {(EW+MW){1'b0}}};
            unf = 1'b1;
            inx = 1'b1;
        end else if (exp_f >= EMAX) begin
            sum = {s_big, {EW{1'b1}}, {MW{1'b0}}};
            ovf = 1'b1;
            inx = 1'b1;
        end else begin
            sum = {s_big, exp_f[EW-1:0], frac_o};
            inx = g_bit | r_bit | s_bit;
        end
    end
endmodule

// File: rtl/fpadd_lane.sv
module fpadd_lane
    import fpadd_pkg::*;
#(
    parameter int EW = 8,
    parameter int MW = 23
) (
    input  logic [EW+MW:0]     op_a,
    input  logic [EW+MW:0]     op_b,
    output logic [EW+MW:0]     sum,
    output logic [NCAUSE-1:0]  cause
);
    localparam logic [EW+MW:0] QNAN = {1'b0, {EW{1'b1}}, {MW{1'b1}}};
    localparam logic [EW+MW:0] NZRO = {1'b1, {(EW+MW){1'b0}}};

    fp_class_e      cls_a, cls_b;
    logic [EW+MW:0] core_sum;
    logic           core_ovf, core_unf, core_inx;

    fpadd_classify #(.EW(EW), .MW(MW)) u_cls_a (.op(op_a), .cls(cls_a));
    fpadd_classify #(.EW(EW), .MW(MW)) u_cls_b (.op(op_b), .cls(cls_b));

    fpadd_core #(.EW(EW), .MW(MW)) u_core (
        .op_a (op_a),
        .op_b (op_b),
        .sum  (core_sum),
        .ovf  (core_ovf),
        .unf  (core_unf),
        .inx  (core_inx)
    );

    always_comb begin
        sum   = '0;
        cause = '0;
        if (cls_a == CL_SNAN || cls_b == CL_SNAN) begin
            sum           = QNAN;
            cause[CB_INV] = 1'b1;
        end else if (cls_a == CL_QNAN || cls_b == CL_QNAN) begin
            sum = QNAN;
        end else if (cls_a == CL_DENORM || cls_b == CL_DENORM) begin
            cause[CB_UNI] = 1'b1;
        end else if (cls_a == CL_INF || cls_b == CL_INF) begin
            if (cls_a == CL_INF && cls_b == CL_INF && op_a[EW+MW] != op_b[EW+MW]) begin
                sum           = QNAN;
                cause[CB_INV] = 1'b1;
            end else if (cls_a == CL_INF) begin
                sum = op_a;
            end else begin
                sum = op_b;
            end
        end else if (cls_a == CL_NORM && cls_b == CL_NORM) begin
            sum           = core_sum;
            cause[CB_OVF] = core_ovf;
            cause[CB_UNF] = core_unf;
            cause[CB_INX] = core_inx;
        end else if (cls_a == CL_NORM) begin
            sum = op_a;
        end else if (cls_b == CL_NORM) begin
            sum = op_b;
        end else if (cls_a == CL_NZERO && cls_b == CL_NZERO) begin
            sum = NZRO;
        end else begin
            sum = '0;
        end
    end
endmodule

// File: rtl/fpadd_unit.sv
module fpadd_unit
    import fpadd_pkg::*;
#(
    parameter int SP_EW = 8,
    parameter int SP_MW = 23,
    parameter int DP_EW = 11,
    parameter int DP_MW = 52
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic                   dbl_mode,
    input  logic [DP_EW+DP_MW:0]   opnd_a,
    input  logic [DP_EW+DP_MW:0]   opnd_b,
    input  logic [NFLAG-1:0]       trap_en,
    input  logic [NFLAG-1:0]       flags_in,
    output logic [DP_EW+DP_MW:0]   result,
    output logic                   dest_we,
    output logic [NCAUSE-1:0]      cause,
    output logic [NFLAG-1:0]       flags_out,
    output logic                   trap_req,
    output logic                   done
);
    localparam int DW     = DP_EW + DP_MW + 1;
    localparam int NLANES = 2;

    typedef struct packed {
        logic              done;
        logic              we;
        logic              trap;
        logic [NCAUSE-1:0] cause;
        logic [NFLAG-1:0]  flags;
        logic [DW-1:0]     res;
    } unit_state_t;

    logic [DW-1:0]     lane_res   [NLANES];
    logic [NCAUSE-1:0] lane_cause [NLANES];

    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        localparam int LEW = (g == 0) ? SP_EW : DP_EW;
        localparam int LMW = (g == 0) ? SP_MW : DP_MW;
        localparam int LW  = LEW + LMW + 1;
        logic [LW-1:0] lsum;

        fpadd_lane #(.EW(LEW), .MW(LMW)) u_lane (
            .op_a  (opnd_a[LW-1:0]),
            .op_b  (opnd_b[LW-1:0]),
            .sum   (lsum),
            .cause (lane_cause[g])
        );
        assign lane_res[g] = DW'(lsum);
    end

    unit_state_t st_d, st_q;
    logic [NCAUSE-1:0] cause_d;

    always_comb begin
        st_d      = st_q;
        st_d.done = start;
        cause_d   = lane_cause[dbl_mode];
        if (start) begin
            st_d.cause = cause_d;
            st_d.res   = lane_res[dbl_mode];
            st_d.flags = flags_in | cause_d[NFLAG-1:0];
            st_d.trap  = trap_en[CB_OVF] | trap_en[CB_UNF] | trap_en[CB_INX]
                       | (cause_d[CB_INV] & trap_en[CB_INV])
                       | cause_d[CB_UNI];
            st_d.we    = ~st_d.trap;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign result    = st_q.res;
    assign dest_we   = st_q.we;
    assign cause     = st_q.cause;
    assign flags_out = st_q.flags;
    assign trap_req  = st_q.trap;
    assign done      = st_q.done;
endmodule

// File: rtl/fpadd_unit_chk.sv
module fpadd_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic [3:0] trap_en,
    input logic       dest_we,
    input logic [4:0] cause,
    input logic [3:0] flags_out,
    input logic       trap_req,
    input logic       done
);
    assert_done_after_start_R13: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(start));

    assert_trap_blocks_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (done && trap_req) |-> !dest_we);

    assert_unimpl_traps_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cause[4]) |-> (trap_req && !dest_we));

    assert_snan_excludes_unimpl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(cause[4] && cause[3]));

    assert_flags_cover_cause_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((flags_out & cause[3:0]) == cause[3:0]));

    assert_forced_trap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(|trap_en[2:0])) |-> trap_req);

    assert_invalid_trap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cause[3] && $past(trap_en[3])) |-> trap_req);

    assert_ovf_inexact_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (cause[2] || cause[1])) |-> cause[0]);
endmodule

bind fpadd_unit fpadd_unit_chk u_fpadd_unit_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .trap_en   (trap_en),
    .dest_we   (dest_we),
    .cause     (cause),
    .flags_out (flags_out),
    .trap_req  (trap_req),
    .done      (done)
);

// File: tb/fpadd_unit_bench.sv
module fpadd_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        dbl_mode = 1'b0;
    logic [63:0] opnd_a = '0, opnd_b = '0;
    logic [3:0]  trap_en = '0, flags_in = '0;
    logic [63:0] result;
    logic        dest_we, trap_req, done;
    logic [4:0]  cause;
    logic [3:0]  flags_out;

    int total = 0;
    int fails = 0;

    always #4 clk = ~clk;   // 125 MHz

    fpadd_unit u_fpadd_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .dbl_mode(dbl_mode),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .trap_en(trap_en), .flags_in(flags_in),
        .result(result), .dest_we(dest_we), .cause(cause), .flags_out(flags_out),
        .trap_req(trap_req), .done(done)
    );

    typedef struct packed {
        logic        dbl;
        logic [63:0] a;
        logic [63:0] b;
        logic [3:0]  ten;
        logic [3:0]  fin;
        logic [63:0] res;
        logic [4:0]  cse;
        logic [3:0]  flg;
        logic        trp;
        logic        we;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 29;
    // cause {E,V,O,U,I}; trap_en / flags {V,O,U,I}
    localparam vec_t VEC [NV] = '{
        '{1'b0, 64'h3F800000, 64'h40000000, 4'h0, 4'h0, 64'h40400000, 5'h00, 4'h0, 1'b0, 1'b1, 4'd7},  // R7 1+2
        '{1'b0, 64'h3FC00000, 64'h3FC00000, 4'h0, 4'h0, 64'h40400000, 5'h00, 4'h0, 1'b0, 1'b1, 4'd7},  // R7 carry out
        '{1'b0, 64'h3F800000, 64'hBF800000, 4'h0, 4'h0, 64'h00000000, 5'h00, 4'h0, 1'b0, 1'b1, 4'd7},  // R7 exact zero
        '{1'b0, 64'h40400000, 64'hBF800000, 4'h0, 4'h0, 64'h40000000, 5'h00, 4'h0, 1'b0, 1'b1, 4'd7},  // R7 subtract
        '{1'b0, 64'h3F800000, 64'h33800000, 4'h0, 4'h0, 64'h3F800000, 5'h01, 4'h1, 1'b0, 1'b1, 4'd7},  // R7 tie to even down
        '{1'b0, 64'h3F800001, 64'h33800000, 4'h0, 4'h0, 64'h3F800002, 5'h01, 4'h1, 1'b0, 1'b1, 4'd7},  // R7 tie to even up
        '{1'b0, 64'h7F7FFFFF, 64'h7F7FFFFF, 4'h0, 4'h0, 64'h7F800000, 5'h05, 4'h5, 1'b0, 1'b1, 4'd8},  // R8 overflow
        '{1'b0, 64'h00800000, 64'h80C00000, 4'h0, 4'h0, 64'h80000000, 5'h03, 4'h3, 1'b0, 1'b1, 4'd8},  // R8 underflow
        '{1'b0, 64'h3F800000, 64'h80000000, 4'h0, 4'h0, 64'h3F800000, 5'h00, 4'h0, 1'b0, 1'b1, 4'd6},  // R6 norm + -0
        '{1'b0, 64'h00000000, 64'hC0400000, 4'h0, 4'h0, 64'hC0400000, 5'h00, 4'h0, 1'b0, 1'b1, 4'd6},  // R6 +0 + norm
        '{1'b0, 64'h80000000, 64'h80000000, 4'h0, 4'h0, 64'h80000000, 5'h00, 4'h0, 1'b0, 1'b1, 4'd6},  // R6 -0 + -0
        '{1'b0, 64'h00000000, 64'h80000000, 4'h0, 4'h0, 64'h00000000, 5'h00, 4'h0, 1'b0, 1'b1, 4'd6},  // R6 +0 + -0
        '{1'b0, 64'h7F800001, 64'h3F800000, 4'h0, 4'h0, 64'h7FFFFFFF, 5'h08, 4'h8, 1'b0, 1'b1, 4'd3},  // R3 sNaN
        '{1'b0, 64'h7FC00000, 64'h7F800001, 4'h0, 4'h0, 64'h7FFFFFFF, 5'h08, 4'h8, 1'b0, 1'b1, 4'd3},  // R3 sNaN beats qNaN
        '{1'b0, 64'h7FC00000, 64'h3F800000, 4'h0, 4'h0, 64'h7FFFFFFF, 5'h00, 4'h0, 1'b0, 1'b1, 4'd4},  // R4 qNaN
        '{1'b0, 64'h00000001, 64'h3F800000, 4'h0, 4'h0, 64'h00000000, 5'h10, 4'h0, 1'b1, 1'b0, 4'd5},  // R5 denormal
        '{1'b0, 64'h7FC00000, 64'h00000001, 4'h0, 4'h0, 64'h7FFFFFFF, 5'h00, 4'h0, 1'b0, 1'b1, 4'd4},  // R4 qNaN beats denormal
        '{1'b0, 64'h7F800000, 64'hFF800000, 4'h0, 4'h0, 64'h7FFFFFFF, 5'h08, 4'h8, 1'b0, 1'b1, 4'd9},  // R9 inf - inf
        '{1'b0, 64'h7F800000, 64'hBF800000, 4'h0, 4'h0, 64'h7F800000, 5'h00, 4'h0, 1'b0, 1'b1, 4'd9},  // R9 inf + finite
        '{1'b1, 64'h3FF0000000000000, 64'h4000000000000000, 4'h0, 4'h0, 64'h4008000000000000, 5'h00, 4'h0, 1'b0, 1'b1, 4'd1},  // R1 double
        '{1'b1, 64'hBFE0000000000000, 64'h3FF0000000000000, 4'h0, 4'h0, 64'h3FE0000000000000, 5'h00, 4'h0, 1'b0, 1'b1, 4'd1},  // R1 double sub
        '{1'b1, 64'h7FF0000000000001, 64'h0000000000000000, 4'h0, 4'h0, 64'h7FFFFFFFFFFFFFFF, 5'h08, 4'h8, 1'b0, 1'b1, 4'd3},  // R3 double sNaN
        '{1'b1, 64'h0000000000000001, 64'h3FF0000000000000, 4'h0, 4'h0, 64'h0000000000000000, 5'h10, 4'h0, 1'b1, 1'b0, 4'd5},  // R5 double denormal
        '{1'b0, 64'h3F800000, 64'h40000000, 4'h1, 4'h0, 64'h40400000, 5'h00, 4'h0, 1'b1, 1'b0, 4'd10}, // R10 forced trap
        '{1'b0, 64'h7F800001, 64'h3F800000, 4'h8, 4'h0, 64'h7FFFFFFF, 5'h08, 4'h8, 1'b1, 1'b0, 4'd11}, // R11 invalid trap
        '{1'b0, 64'h3F800000, 64'h40000000, 4'h8, 4'h0, 64'h40400000, 5'h00, 4'h0, 1'b0, 1'b1, 4'd10}, // R10 no forced trap
        '{1'b0, 64'h3F800000, 64'h33800000, 4'h0, 4'hA, 64'h3F800000, 5'h01, 4'hB, 1'b0, 1'b1, 4'd12}, // R12 sticky
        '{1'b0, 64'h3F800000, 64'h40000000, 4'h0, 4'hF, 64'h40400000, 5'h00, 4'hF, 1'b0, 1'b1, 4'd2},  // R2 cause cleared
        '{1'b0, 64'hDEADBEEF3F800000, 64'h1234567840000000, 4'h0, 4'h0, 64'h40400000, 5'h00, 4'h0, 1'b0, 1'b1, 4'd1}  // R1 upper ignored
    };

    task automatic check(input int req, input string what, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic run_op(input logic dbl, input logic [63:0] a, input logic [63:0] b,
                          input logic [3:0] ten, input logic [3:0] fin);
        @(negedge clk);
        dbl_mode = dbl;
        opnd_a   = a;
        opnd_b   = b;
        trap_en  = ten;
        flags_in = fin;
        start    = 1'b1;
        @(negedge clk);
        start    = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        total++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R13 reset state
        check(13, "reset done",   64'(done),     64'h0);
        check(13, "reset we",     64'(dest_we),  64'h0);
        check(13, "reset result", result,        64'h0);
        check(13, "reset cause",  64'(cause),    64'h0);
        check(13, "reset trap",   64'(trap_req), 64'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            run_op(VEC[i].dbl, VEC[i].a, VEC[i].b, VEC[i].ten, VEC[i].fin);
            check(13, "done", 64'(done), 64'h1);
            check(int'(VEC[i].req), "result", result,         VEC[i].res);
            check(int'(VEC[i].req), "cause",  64'(cause),     64'(VEC[i].cse));
            check(int'(VEC[i].req), "flags",  64'(flags_out), 64'(VEC[i].flg));
            check(int'(VEC[i].req), "trap",   64'(trap_req),  64'(VEC[i].trp));
            check(int'(VEC[i].req), "we",     64'(dest_we),   64'(VEC[i].we));
        end

        // R13 done is a single pulse and outputs hold
        run_op(1'b0, 64'h3F800000, 64'h40000000, 4'h0, 4'h0);
        opnd_a = 64'h7F800001;
        opnd_b = 64'h00000001;
        @(negedge clk);
        check(13, "done pulse ends", 64'(done), 64'h0);
        check(13, "result holds",    result,    64'h40400000);
        check(13, "cause holds",     64'(cause), 64'h0);

        // R2 cause from an invalid op does not linger into the next op
        run_op(1'b0, 64'h7F800001, 64'h3F800000, 4'h0, 4'h0);
        check(2, "invalid cause", 64'(cause), 64'h08);
        run_op(1'b0, 64'h40400000, 64'hBF800000, 4'h0, 4'h0);
        check(2, "cause cleared", 64'(cause), 64'h00);
        check(2, "result",        result,     64'h40000000);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule